// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets an external two-wire bus master read and write a bank of 8-bit configuration registers that lives next to it on the chip. The clock and data lines are brought into the system clock domain, start and stop conditions are found by comparing the two lines, and a byte-level state machine answers the master. It acknowledges its own device address and takes in a register sub-address. It then either commits one or more data bytes to the register bank or streams register contents back to the master, most significant bit first.

The device address is a fixed three-bit prefix followed by three strap inputs set by the board. This lets up to eight copies share one bus. A transfer that carries only the sub-address and then stops just loads the internal pointer. A later read transfer starts from that pointer. After every byte written or read the pointer moves on by one, so bursts walk through consecutive registers. The data line is open-drain: the block never drives it high, it only asserts an output-enable that pulls it low.

The register bank is outside this block. It is reached through a simple port: a one-cycle write strobe with address and data, and a one-cycle read strobe whose data is returned on the next clock. The system clock must run at least 16 times faster than the bus clock.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The address byte is accepted only when bits [7:5] are 110, bits [4:2] equal the strap inputs, and bit 1 is 0. Bit 0 is the direction: 1 is read, 0 is write. With strap 011 the write byte is 0xCC and the read byte is 0xCD. On a mismatch the slave does not acknowledge and ignores the bus until the next START.
- R2: For every byte it receives after a matching address, the slave pulls SDA low for the whole ninth SCL clock.
- R3: A write transfer (address with direction 0, sub-address, data, STOP) produces exactly one one-cycle write strobe, carrying the sub-address and the data byte.
- R4: A transfer carrying only the address and sub-address before STOP loads the pointer and produces no write strobe.
- R5: A read transfer returns the register at the pointer, MSB first. Each later byte that the master acknowledges returns the next register.
- R6: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START.
- R7: While the enable input is low, the slave never pulls SDA low and produces no write strobes, whatever the bus carries.
- R8: The slave starts pulling SDA low only while SCL is low. It is idle with SDA released after reset.
- R9: A START seen at any point restarts address reception. A repeated START may directly follow a sub-address. A STOP in the middle of a data byte cancels that byte.
- R10: In a write transfer with several data bytes, each byte goes to the next consecutive register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Interface enable; low makes the slave ignore the bus |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | High pulls the data line low |
| strap | input | 3 | Board-set low bits of the device address |
| reg_addr | output | REG_AW | Register bank address |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_rd |

## Verification
Two events can meet in one clock. A START or STOP can arrive while the byte machine is partway through a byte or holds a pending acknowledge. The bench provokes this with a STOP after four data bits, which must leave no write strobe and leave the target register unchanged when it is read back. It also sends a repeated START straight after the sub-address acknowledge, which must restart address reception while keeping the freshly loaded pointer. The read that follows must return that register's value. Because a read prefetch is issued at the end of each byte, the bench also sends a NACK and then clocks a full extra byte, and requires the line to stay high throughout.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } bus_state_t;

  localparam int BYTE_W = 8;
  localparam logic [3:0] BITS_FULL = 4'd8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int TOP = STAGES - 1;

  logic [1:0] line_raw;
  logic [1:0] line_now;
  logic [1:0] line_prev;

  assign line_raw = {scl_i, sda_i};

  // one synchroniser chain per bus line
  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) begin
        pipe         <= '1;
        line_prev[g] <= 1'b1;
      end else begin
        pipe         <= {pipe[TOP-1:0], line_raw[g]};
        line_prev[g] <= pipe[TOP];
      end
    end
    assign line_now[g] = pipe[TOP];
  end

  assign scl_s     = line_now[1];
  assign sda_s     = line_now[0];
  assign scl_rise  = line_now[1] & ~line_prev[1];
  assign scl_fall  = ~line_now[1] & line_prev[1];
  assign start_evt = line_now[1] & line_prev[1] & line_prev[0] & ~line_now[0];
  assign stop_evt  = line_now[1] & line_prev[1] & ~line_prev[0] & line_now[0];

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter logic [2:0] PREFIX = 3'b110,
  parameter logic       TAIL   = 1'b0
) (
  input  logic [7:0] rx_byte,
  input  logic [2:0] strap,
  output logic       hit,
  output logic       rw
);

  assign hit = (rx_byte[7:5] == PREFIX) && (rx_byte[4:2] == strap) && (rx_byte[1] == TAIL);
  assign rw  = rx_byte[0];

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import i2c_cfg_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              addr_hit,
  input  logic              addr_rw,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sda_oe,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd
);

  bus_state_t        state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [REG_AW-1:0] ptr;
  logic              dir_rd;
  logic              m_nack;
  logic              rx_state;
  logic              byte_in;

  assign rx_byte  = rx_sh;
  assign rx_state = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_WDATA);
  assign byte_in  = rx_state && scl_fall && (bit_cnt == BITS_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      dir_rd    <= 1'b0;
      m_nack    <= 1'b1;
      sda_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (!en) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        // shared bit collection for the three receive states
        if (rx_state && scl_rise && (bit_cnt != BITS_FULL)) begin
          rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end
        case (state)
          ST_ADDR: begin
            if (byte_in) begin
              if (addr_hit) begin
                sda_oe <= 1'b1;
                dir_rd <= addr_rw;
                state  <= ST_ADDR_ACK;
                if (addr_rw) begin
                  reg_addr <= ptr;
                  reg_rd   <= 1'b1;
                end
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (dir_rd) begin
                tx_sh  <= reg_rdata;
                sda_oe <= ~reg_rdata[BYTE_W-1];
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_SUB;
              end
            end
          end
          ST_SUB: begin
            if (byte_in) begin
              ptr    <= rx_sh[REG_AW-1:0];
              sda_oe <= 1'b1;
              state  <= ST_SUB_ACK;
            end
          end
          ST_SUB_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_WDATA;
            end
          end
          ST_WDATA: begin
            if (byte_in) begin
              reg_addr  <= ptr;
              reg_wdata <= rx_sh;
              reg_wr    <= 1'b1;
              ptr       <= ptr + 1'b1;
              sda_oe    <= 1'b1;
              state     <= ST_WDATA_ACK;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                sda_oe   <= 1'b0;
                ptr      <= ptr + 1'b1;
                reg_addr <= ptr + 1'b1;
                reg_rd   <= 1'b1;
                state    <= ST_RACK;
              end else begin
                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_oe  <= ~tx_sh[BYTE_W-2];
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_nack <= sda_s;
            end else if (scl_fall) begin
              if (m_nack) begin
                state <= ST_IDLE;
              end else begin
                tx_sh   <= reg_rdata;
                sda_oe  <= ~reg_rdata[BYTE_W-1];
                bit_cnt <= '0;
                state   <= ST_RDATA;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R7
  en_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sda_oe);

  // R8
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_s));

  // R3
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  // R3
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (en && start_evt) |=> (state == ST_ADDR) && !sda_oe);

  // R6
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter int         REG_AW      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] DEV_PREFIX  = 3'b110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_wr,
  output logic [7:0]        reg_wdata,
  output logic              reg_rd,
  input  logic [7:0]        reg_rdata
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic addr_hit, addr_rw;
  logic [7:0] rx_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_addr_match #(.PREFIX(DEV_PREFIX), .TAIL(1'b0)) u_match (
    .rx_byte (rx_byte),
    .strap   (strap),
    .hit     (addr_hit),
    .rw      (addr_rw)
  );

  i2c_proto_fsm #(.REG_AW(REG_AW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .addr_hit  (addr_hit),
    .addr_rw   (addr_rw),
    .reg_rdata (reg_rdata),
    .rx_byte   (rx_byte),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd)
  );

endmodule

// File: tb/sim_i2c_cfg_slave.sv
module sim_i2c_cfg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam logic [7:0] DEV_W = 8'hCC;
  localparam logic [7:0] DEV_R = 8'hCD;
  localparam logic [15:0] VEC [6] = '{16'h103C, 16'h11A5, 16'h120F, 16'h80FF, 16'hFE00, 16'h0196};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] strap = 3'b011;
  logic sda_oe, sda_bus;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic reg_wr, reg_rd;

  logic [7:0] mem [256];
  int wr_cnt = 0;
  logic [7:0] last_a, last_d;
  logic oe_prev = 1'b0;
  int bad_edge = 0, en_viol = 0;
  int checks = 0, fails = 0;
  logic done = 1'b0;
  logic [7:0] rbuf [4];

  assign sda_bus = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cfg_slave u0 (
    .clk(clk), .rst(rst), .en(en), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap(strap), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  // register bank model and port monitors
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      reg_rdata <= 8'h00;
    end else begin
      if (reg_wr) begin
        mem[reg_addr] <= reg_wdata;
        wr_cnt <= wr_cnt + 1;
        last_a <= reg_addr;
        last_d <= reg_wdata;
      end
      if (reg_rd) reg_rdata <= mem[reg_addr];
    end
    oe_prev <= sda_oe;
    if (sda_oe && !oe_prev && scl) bad_edge <= bad_edge + 1;
    if (!en && !rst && sda_oe) en_viol <= en_viol + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(Q); scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
    end
    m_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q); ack = !sda_bus; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q); b[i] = sda_bus; wt(Q); scl = 1'b0; wt(Q);
    end
    m_sda = nack; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q); m_sda = 1'b1;
  endtask

  task automatic wr_reg(input logic [7:0] dev, input logic [7:0] sub, input logic [7:0] d, output logic ack);
    logic a0, a1, a2;
    bus_start(); send_byte(dev, a0); send_byte(sub, a1); send_byte(d, a2); bus_stop();
    ack = a0 & a1 & a2;
  endtask

  // pointer-only write, stop, then read n bytes (last one NACKed)
  task automatic rd_regs(input logic [7:0] sub, input int n);
    logic a0, a1;
    bus_start(); send_byte(DEV_W, a0); send_byte(sub, a1); bus_stop();
    bus_start(); send_byte(DEV_R, a0);
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k == n - 1);
    bus_stop();
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic ack, a0, a1;
    int wc;
    wt(5);
    chk("R8 reset oe", sda_oe, 0);
    chk("R8 reset wr", reg_wr, 0);
    chk("R8 reset rd", reg_rd, 0);
    rst = 1'b0; en = 1'b1; wt(4);
    chk("R8 idle oe", sda_oe, 0);

    // table-driven writes
    for (int v = 0; v < 6; v++) begin
      wc = wr_cnt;
      wr_reg(DEV_W, VEC[v][15:8], VEC[v][7:0], ack); wt(2);
      chk("R2 write acks", ack, 1);
      chk("R3 one strobe", wr_cnt, wc + 1);
      chk("R3 strobe addr", last_a, VEC[v][15:8]);
      chk("R3 strobe data", last_d, VEC[v][7:0]);
    end
    // table-driven readback via pointer-only writes
    for (int v = 0; v < 6; v++) begin
      wc = wr_cnt;
      rd_regs(VEC[v][15:8], 1); wt(2);
      chk("R4 no strobe on pointer load", wr_cnt, wc);
      chk("R5 read value", rbuf[0], VEC[v][7:0]);
    end

    // sequential read burst
    rd_regs(8'h10, 3);
    chk("R5 burst b0", rbuf[0], 8'h3C);
    chk("R5 burst b1", rbuf[1], 8'hA5);
    chk("R5 burst b2", rbuf[2], 8'h0F);

    // NACK then a further clocked byte must read all ones
    bus_start(); send_byte(DEV_W, a0); send_byte(8'h11, a1); bus_stop();
    bus_start(); send_byte(DEV_R, a0);
    recv_byte(rbuf[0], 1'b1);
    chk("R6 oe released after nack", sda_oe, 0);
    recv_byte(rbuf[1], 1'b1);
    chk("R6 no drive after nack", rbuf[1], 8'hFF);
    bus_stop();

    // multi-byte write
    wc = wr_cnt;
    bus_start(); send_byte(DEV_W, a0); send_byte(8'h40, a1);
    send_byte(8'hA1, ack); send_byte(8'hA2, ack); bus_stop(); wt(2);
    chk("R10 two strobes", wr_cnt, wc + 2);
    chk("R10 second addr", last_a, 8'h41);
    rd_regs(8'h40, 2);
    chk("R10 reg 40", rbuf[0], 8'hA1);
    chk("R10 reg 41", rbuf[1], 8'hA2);

    // repeated START after sub-address
    bus_start(); send_byte(DEV_W, a0); send_byte(8'h12, a1);
    bus_start(); send_byte(DEV_R, a0);
    chk("R9 repeated start ack", a0, 1);
    recv_byte(rbuf[0], 1'b1); bus_stop();
    chk("R9 repeated start data", rbuf[0], 8'h0F);

    // STOP after four data bits cancels the byte
    wc = wr_cnt;
    bus_start(); send_byte(DEV_W, a0); send_byte(8'h50, a1);
    for (int i = 0; i < 4; i++) begin
      m_sda = 1'b1; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
    end
    bus_stop(); wt(2);
    chk("R9 aborted byte no strobe", wr_cnt, wc);
    rd_regs(8'h50, 1);
    chk("R9 aborted reg unchanged", rbuf[0], 8'h0A);

    // address mismatch
    wc = wr_cnt;
    bus_start(); send_byte(8'hC8, a0); send_byte(8'h77, a1); bus_stop(); wt(2);
    chk("R1 wrong strap no ack", a0, 0);
    chk("R1 ignored until start", a1, 0);
    bus_start(); send_byte(8'hCE, a0); bus_stop();
    chk("R1 bit1 set no ack", a0, 0);
    chk("R1 no strobe", wr_cnt, wc);
    strap = 3'b101; wt(4);
    wr_reg(8'hD4, 8'h60, 8'h3E, ack); wt(2);
    chk("R1 new strap ack", ack, 1);
    chk("R1 new strap data", last_d, 8'h3E);
    wr_reg(DEV_W, 8'h61, 8'h11, ack);
    chk("R1 old address refused", ack, 0);
    strap = 3'b011; wt(4);

    // enable low
    wc = wr_cnt;
    en = 1'b0; wt(2);
    wr_reg(DEV_W, 8'h61, 8'h99, ack); wt(2);
    chk("R7 no ack when disabled", ack, 0);
    chk("R7 no strobe when disabled", wr_cnt, wc);
    chk("R7 never drove", en_viol, 0);
    en = 1'b1; wt(4);
    rd_regs(8'h61, 1);
    chk("R7 reg untouched", rbuf[0], 8'h3B);

    chk("R8 drive only while scl low", bad_edge, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule